// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire management bus between a MAC and external PHY devices. Software writes a single command word that holds the whole transaction: opcode, PHY address, register address, write data and a start bit. The block then generates the management clock, shifts a Clause 22 frame onto a tri-stated data line and, on reads, captures the 16 returned bits into the same command word. A busy bit shows progress and clears by itself at the end of the frame. A read-fail flag records a PHY that did not pull the line low during turnaround.

A second register holds the clock divider, a preamble-suppress bit and a framing-select bit. The management clock runs at the reference clock divided by 2×(divider+1), so a 250 MHz reference with divider 49 gives 2.5 MHz. A one-bit select chooses the register: 0 for the command word (offset 0x00), 1 for the configuration word (offset 0x04). Reads are combinational.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration word reads with divider field (bits 9:4) equal to 49, bit 0 = 1 (Clause 22 selected) and bit 12 = 0 (preamble on). The command word reads 0, MDC is low and the data output enable is low.
- R2: The command word has busy/start at bit 29, read-fail at bit 28, opcode at 27:26, PHY address at 25:21, register address at 20:16 and data at 15:0. Writing it while idle stores the fields. If bit 29 is written as 1, a frame starts and bit 29 reads 1 until the frame completes, then returns to 0 without software action.
- R3: While a frame runs, MDC is high for divider+1 reference cycles and low for divider+1 reference cycles, starting low. Between frames MDC is held low.
- R4: A frame is 32 ones of preamble, then start bits 01, the opcode (10 = read, 01 = write), the 5-bit PHY address, the 5-bit register address, 2 turnaround bits and 16 data bits. Every field is sent MSB first. Setting configuration bit 12 removes the preamble.
- R5: The data output changes only right after an MDC falling edge and stays constant while MDC is high. On a write, the master drives turnaround as 1 then 0, followed by the 16 data bits.
- R6: On a read, the output enable is low from the first turnaround bit to the end of the frame. Incoming bits are sampled on MDC rising edges, and the 16 data bits land in command bits 15:0 MSB first.
- R7: On a read, bit 28 is set when the second turnaround bit samples high. The data is captured regardless. Bit 28 is cleared when the next frame starts.
- R8: While busy, writes to the command word have no effect: they neither change its fields nor start another frame.
- R9: Configuration bit 0 is stored and read back as written. The frame is always produced in Clause 22 format, whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Two functions can coincide in one cycle: a new command-word write and the final MDC falling edge that ends a frame. At that edge the busy bit is still set, so the write must be dropped and must not start a second frame. The bench provokes this by timing a start write onto the exact completion edge, then issuing another start in the first idle cycle. A behavioural model tracks both writes. It is compared every cycle on MDC, data, output enable and the full command word, so a frame started too early, or fields overwritten, both show as mismatches.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_LEN = 32,
  parameter int DIV_RST = 49
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PRE_W   = $clog2(PRE_LEN + 1);
  localparam int TA_POS  = 14;
  localparam int DAT_POS = 16;
  localparam int LAST    = 31;

  logic        busy, fail, c22, nopre, mdc_q;
  logic [1:0]  op;
  logic [4:0]  phy, rga, fbit;
  logic [15:0] data;
  logic [5:0]  div, cnt;
  logic [PRE_W-1:0] pre_left;
  logic [31:0] sr;

  wire tick   = busy && (cnt == div);
  wire rise   = tick && !mdc_q;
  wire fall   = tick && mdc_q;
  wire is_rd  = (op == 2'b10);
  wire in_pre = (pre_left != '0);
  wire cmd_wr = reg_wr && !reg_sel && !busy;
  wire unused_bits = ^reg_wdata[31:30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fail <= 1'b0; c22 <= 1'b1; nopre <= 1'b0;
      div <= 6'(DIV_RST); cnt <= '0; mdc_q <= 1'b0;
      op <= '0; phy <= '0; rga <= '0; data <= '0;
      pre_left <= '0; fbit <= '0; sr <= '0;
    end else begin
      if (reg_wr && reg_sel) begin
        c22   <= reg_wdata[0];
        div   <= reg_wdata[9:4];
        nopre <= reg_wdata[12];
      end
      if (cmd_wr) begin
        op   <= reg_wdata[27:26];
        phy  <= reg_wdata[25:21];
        rga  <= reg_wdata[20:16];
        data <= reg_wdata[15:0];
        if (reg_wdata[29]) begin
          busy     <= 1'b1;
          fail     <= 1'b0;
          cnt      <= '0;
          mdc_q    <= 1'b0;
          fbit     <= '0;
          pre_left <= nopre ? '0 : PRE_W'(PRE_LEN);
          sr <= {2'b01, reg_wdata[27:16], 2'b10, reg_wdata[15:0]};
        end
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 6'd1;
        if (tick) mdc_q <= !mdc_q;
        if (rise && is_rd && !in_pre) begin
          if (fbit == 5'(TA_POS + 1)) fail <= mdio_i;
          if (fbit >= 5'(DAT_POS)) data <= {data[14:0], mdio_i};
        end
        if (fall) begin
          if (in_pre) pre_left <= pre_left - 1'b1;
          else if (fbit == 5'(LAST)) begin
            busy  <= 1'b0;
            mdc_q <= 1'b0;
          end else begin
            fbit <= fbit + 5'd1;
            sr   <= {sr[30:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = in_pre | sr[31];
  assign mdio_oe = busy && (in_pre || !is_rd || fbit < 5'(TA_POS));

  assign reg_rdata = reg_sel
    ? {19'b0, nopre, 2'b0, div, 3'b0, c22}
    : {2'b0, busy, fail, op, phy, rga, data};

  assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_q);

  assert_hold_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mdc_q && $past(mdc_q) |-> $stable(mdio_o) && $stable(mdio_oe));

  assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mdc_q));

  assert_start_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && !reg_sel && reg_wdata[29]));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && !reg_sel |=> $stable({op, phy, rga}));

  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0, mdio_i = 1'b1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int tests = 0, fails = 0;

  mdio_master dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #10 clk = !clk;

  // behavioural reference model
  logic        m_busy, m_fail, m_c22, m_nopre, m_rd;
  logic [1:0]  m_op;
  logic [4:0]  m_phy, m_rga;
  logic [15:0] m_data;
  int          m_div, m_half, m_t, m_n;
  logic        e_o [64];
  logic        e_oe[64];
  logic        p_in[64];
  logic [15:0] resp = 16'h0;
  logic        ta_bad = 1'b0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic build_frame();
    logic [31:0] f;
    int p;
    p = m_nopre ? 0 : 32;
    m_n = p + 32;
    f = {2'b01, m_op, m_phy, m_rga, 2'b10, m_data};
    for (int i = 0; i < p; i++) begin e_o[i] = 1'b1; e_oe[i] = 1'b1; p_in[i] = 1'b1; end
    for (int j = 0; j < 32; j++) begin
      e_o[p+j]  = f[31-j];
      e_oe[p+j] = !(m_rd && j >= 14);
      p_in[p+j] = (j == 15) ? ta_bad : (j >= 16) ? resp[31-j] : 1'b1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_fail = 0; m_c22 = 1; m_nopre = 0; m_div = 49; m_rd = 0;
      m_op = 0; m_phy = 0; m_rga = 0; m_data = 0; m_t = 0; m_half = 50; m_n = 64;
    end else begin
      logic ob;
      ob = m_busy;
      if (m_busy) begin
        m_t++;
        if (m_t == m_n * 2 * m_half) begin
          m_busy = 0;
          if (m_rd) begin m_data = resp; m_fail = ta_bad; end
        end
      end
      if (reg_wr && reg_sel) begin
        m_c22 = reg_wdata[0]; m_div = int'(reg_wdata[9:4]); m_nopre = reg_wdata[12];
      end
      if (reg_wr && !reg_sel && !ob) begin
        m_op = reg_wdata[27:26]; m_phy = reg_wdata[25:21];
        m_rga = reg_wdata[20:16]; m_data = reg_wdata[15:0];
        if (reg_wdata[29]) begin
          m_busy = 1; m_t = 0; m_fail = 0; m_half = m_div + 1;
          m_rd = (m_op == 2'b10);
          build_frame();
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      int b; logic emdc, eoe;
      b = m_busy ? m_t / (2 * m_half) : 0;
      emdc = m_busy && ((m_t % (2 * m_half)) >= m_half);
      eoe  = m_busy && e_oe[b];
      check("R3", "mdc", 32'(mdc), 32'(emdc));
      check("R6", "mdio_oe", 32'(mdio_oe), 32'(eoe));
      if (eoe) check("R4", "mdio_o", 32'(mdio_o), 32'(e_o[b]));
      if (!reg_sel) begin
        check("R2", "busy", 32'(reg_rdata[29]), 32'(m_busy));
        if (!m_busy)
          check("R7", "cmd word", reg_rdata,
                {2'b0, 1'b0, m_fail, m_op, m_phy, m_rga, m_data});
      end else
        check("R9", "cfg word", reg_rdata,
              {19'b0, m_nopre, 2'b0, 6'(m_div), 3'b0, m_c22});
      mdio_i = m_busy ? p_in[b] : 1'b1;
    end
  end

  function automatic logic [31:0] cmd(logic st, logic [1:0] op, logic [4:0] ph,
                                      logic [4:0] rg, logic [15:0] d);
    return {2'b0, st, 1'b0, op, ph, rg, d};
  endfunction

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && m_busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    check("R1", "cmd reset", reg_rdata, 32'h0);
    check("R1", "mdc reset", 32'(mdc), 32'h0);
    check("R1", "oe reset", 32'(mdio_oe), 32'h0);
    reg_sel = 1'b1; #1;
    check("R1", "cfg reset", reg_rdata, 32'h0000_0311);
    @(negedge clk); reg_sel = 1'b0;

    // R2: store fields without start
    wr(1'b0, cmd(1'b0, 2'b01, 5'd3, 5'd4, 16'h00FF));
    repeat (4) @(negedge clk);

    // R4 R5: write with preamble at default divider, R8 write while busy mid-frame
    wr(1'b0, cmd(1'b1, 2'b01, 5'd5, 5'd26, 16'hA53C));
    repeat (300) @(negedge clk);
    wr(1'b0, cmd(1'b1, 2'b10, 5'd9, 5'd1, 16'h1111));
    wait_idle();

    // R9: Clause 45 select stored, preamble suppressed, divider 2
    wr(1'b1, 32'h0000_1020);
    reg_sel = 1'b1; repeat (2) @(negedge clk); reg_sel = 1'b0;
    // R6: read with good turnaround
    resp = 16'h1234; ta_bad = 1'b0;
    wr(1'b0, cmd(1'b1, 2'b10, 5'd17, 5'd2, 16'h0000));
    wait_idle();

    // R7: read with turnaround failure, preamble on, divider 0
    wr(1'b1, 32'h0000_0001);
    resp = 16'hBEEF; ta_bad = 1'b1;
    wr(1'b0, cmd(1'b1, 2'b10, 5'd31, 5'd31, 16'h5555));
    wait_idle();

    // R7: next start clears the fail flag; R8 write on the completion edge
    ta_bad = 1'b0;
    wr(1'b1, 32'h0000_1011);
    wr(1'b0, cmd(1'b1, 2'b01, 5'd1, 5'd7, 16'h8001));
    for (int k = 0; k < 20000; k++) begin
      if (m_busy && m_t == m_n * 2 * m_half - 1) break;
      @(negedge clk);
    end
    reg_wr = 1'b1; reg_sel = 1'b0;
    reg_wdata = cmd(1'b1, 2'b10, 5'd2, 5'd3, 16'h0000);
    @(negedge clk);
    reg_wdata = cmd(1'b1, 2'b01, 5'd12, 5'd13, 16'h7E81);
    @(negedge clk);
    reg_wr = 1'b0;
    wait_idle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule